// File: doc/BRIEF.md
# Programmable-Logic Output Macrocell

This block is one output cell of a small sum-of-products logic device. Eight product terms come in from the AND array. A set of static configuration bits picks one of four personalities for the cell:

- a clocked output,
- a plain combinational output,
- a combinational output whose pin can also serve as an input,
- a pure input that passes a neighbouring pin back into the array.

Whatever the personality, the cell produces three signals: a data value for its pin, a tri-state enable for that pin, and a feedback signal that returns to the array.

Two global mode bits are shared by every cell of the device. Two local bits belong to this cell alone: one chooses the personality together with the globals, and one sets the output polarity through an exclusive-OR placed after the OR gate. Four internal selectors are driven from these bits. They steer the product-term routing, the enable source, the output source and the feedback source.

The two cells at the ends of the row take their feedback selection from the other global bit. The `CELL_IDX` and `NUM_CELLS` parameters place the cell in the row. The `HAS_DED_FB` parameter marks cells that return no feedback when they act as a dedicated output.

The datapath has no flow control. The configuration pins are static, and the data pins are plain levels. The register has no reset, so it holds whatever was last clocked into it.

Top module: `plm_macrocell`

## Requirements
- R1: In clocked mode (`glb_noreg_i`=0, `glb_regfam_i`=1, `loc_mode_i`=0), each rising `clk` edge loads the register with the OR of all eight product terms XOR `loc_inv_i`. `pin_data_o` shows the register and does not follow product-term changes between edges.
- R2: In clocked mode, `pin_oe_o` is 1 exactly when the active-low `oe_n_i` is 0.
- R3: In clocked mode, `fb_o` equals the register value, the same value shown on `pin_data_o`.
- R4: `loc_inv_i`=1 inverts the sum before it reaches the pin or the register; `loc_inv_i`=0 passes it unchanged.
- R5: In dedicated-output mode (`glb_noreg_i`=1, `glb_regfam_i`=0, `loc_mode_i`=0), `pin_oe_o` is always 1. `pin_data_o` is the OR of all eight terms, `pterm_i[0]` included, XOR `loc_inv_i`, with no clock involved.
- R6: In combinational I/O mode (`glb_regfam_i`=1, `loc_mode_i`=1), `pin_oe_o` equals `pterm_i[0]`. `pin_data_o` is the OR of `pterm_i[7:1]` XOR `loc_inv_i`, and `pterm_i[0]` has no effect on it.
- R7: In combinational I/O mode, a cell that is not at either end of the row drives `fb_o` from its own pin value `pin_in_i`.
- R8: In dedicated-input mode (`glb_regfam_i`=0, `loc_mode_i`=1), `pin_oe_o` is always 0 and `fb_o` equals the neighbouring pin `nbr_pin_i`.
- R9: In dedicated-output mode, `fb_o` equals `nbr_pin_i` when `HAS_DED_FB`=1 and is held at 0 when `HAS_DED_FB`=0.
- R10: The end cells (index 0 and `NUM_CELLS`-1) use the inverse of `glb_noreg_i` instead of `glb_regfam_i` on the feedback selector only. With both global bits at 1 and `loc_mode_i`=1, an end cell therefore feeds back `nbr_pin_i` while its pin still behaves as a combinational I/O.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock, rising edge |
| pterm_i | input | NUM_PT | Product terms from the AND array |
| oe_n_i | input | 1 | Device-wide output enable, active low, used in clocked mode |
| glb_noreg_i | input | 1 | Global bit: 1 selects a device without registers |
| glb_regfam_i | input | 1 | Global bit: 1 selects the registered family decode |
| loc_mode_i | input | 1 | Local personality bit |
| loc_inv_i | input | 1 | Local polarity bit, 1 inverts |
| pin_in_i | input | 1 | Value present on this cell's own pin |
| nbr_pin_i | input | 1 | Value present on the adjacent pin |
| pin_data_o | output | 1 | Data driven toward the pin |
| pin_oe_o | output | 1 | Tri-state enable for the pin, 1 drives |
| fb_o | output | 1 | Feedback into the array |

## Verification
A wrong selector state inside the cell shows at the pins at once. A misrouted enable appears on `pin_oe_o` in the same cycle as the configuration change, and a wrong feedback source appears on `fb_o` as soon as `pin_in_i` and `nbr_pin_i` are driven to opposite levels. A fault in the register path becomes visible one rising edge after the terms change: either `pin_data_o` follows the terms before the edge, or it fails to take the expected value after it. The end-cell and no-feedback variants are instantiated beside the middle cell and receive the same stimulus, so a selector that ignores its position parameter shows as a mismatch between the instances.

// File: rtl/plm_pkg.sv
package plm_pkg;

  typedef enum logic [1:0] {
    PERS_DED_OUT = 2'b00,
    PERS_DED_IN  = 2'b01,
    PERS_REG     = 2'b10,
    PERS_CMB_IO  = 2'b11
  } pers_e;

  function automatic pers_e pers_decode(input logic fam, input logic loc);
    return pers_e'({fam, loc});
  endfunction

endpackage

// File: rtl/plm_term_sum.sv
module plm_term_sum #(
  parameter int NUM_PT = 8
) (
  input  logic [NUM_PT-1:0] pterm_i,
  input  logic              steal_first_i,
  output logic              sum_o
);

  logic [NUM_PT-1:0] used;

  assign used[0] = pterm_i[0] & ~steal_first_i;

  for (genvar gi = 1; gi < NUM_PT; gi++) begin : g_term
    assign used[gi] = pterm_i[gi];
  end

  assign sum_o = |used;

endmodule

// File: rtl/plm_out_reg.sv
module plm_out_reg (
  input  logic clk,
  input  logic d_i,
  output logic q_o
);

  always_ff @(posedge clk) begin
    q_o <= d_i;
  end

endmodule

// File: rtl/plm_fb_sel.sv
module plm_fb_sel #(
  parameter bit HAS_DED_FB = 1'b1
) (
  input  logic fam_i,
  input  logic loc_i,
  input  logic q_i,
  input  logic pin_in_i,
  input  logic nbr_pin_i,
  output logic fb_o
);
  import plm_pkg::*;

  pers_e sel;
  assign sel = pers_decode(fam_i, loc_i);

  always_comb begin
    unique case (sel)
      PERS_REG:     fb_o = q_i;
      PERS_CMB_IO:  fb_o = pin_in_i;
      PERS_DED_IN:  fb_o = nbr_pin_i;
      default:      fb_o = HAS_DED_FB ? nbr_pin_i : 1'b0;
    endcase
  end

endmodule

// File: rtl/plm_macrocell.sv
module plm_macrocell #(
  parameter int NUM_PT     = 8,
  parameter int NUM_CELLS  = 8,
  parameter int CELL_IDX   = 3,
  parameter bit HAS_DED_FB = 1'b1
) (
  input  logic              clk,
  input  logic [NUM_PT-1:0] pterm_i,
  input  logic              oe_n_i,
  input  logic              glb_noreg_i,
  input  logic              glb_regfam_i,
  input  logic              loc_mode_i,
  input  logic              loc_inv_i,
  input  logic              pin_in_i,
  input  logic              nbr_pin_i,
  output logic              pin_data_o,
  output logic              pin_oe_o,
  output logic              fb_o
);
  import plm_pkg::*;

  localparam bit IS_EDGE = (CELL_IDX == 0) || (CELL_IDX == NUM_CELLS - 1);

  pers_e pers;
  logic  sum;
  logic  pol_sum;
  logic  q;
  logic  fb_fam;

  assign pers = pers_decode(glb_regfam_i, loc_mode_i);

  // term routing: the enable term is withheld from the sum in I/O mode
  plm_term_sum #(.NUM_PT(NUM_PT)) u_sum (
    .pterm_i       (pterm_i),
    .steal_first_i (pers == PERS_CMB_IO),
    .sum_o         (sum)
  );

  assign pol_sum = sum ^ loc_inv_i;

  plm_out_reg u_reg (
    .clk (clk),
    .d_i (pol_sum),
    .q_o (q)
  );

  // enable source
  always_comb begin
    unique case (pers)
      PERS_REG:    pin_oe_o = ~oe_n_i;
      PERS_CMB_IO: pin_oe_o = pterm_i[0];
      PERS_DED_IN: pin_oe_o = 1'b0;
      default:     pin_oe_o = 1'b1;
    endcase
  end

  // output source
  assign pin_data_o = (pers == PERS_REG) ? q : pol_sum;

  // end cells steer feedback from the other global bit
  assign fb_fam = IS_EDGE ? ~glb_noreg_i : glb_regfam_i;

  plm_fb_sel #(.HAS_DED_FB(HAS_DED_FB)) u_fb (
    .fam_i     (fb_fam),
    .loc_i     (loc_mode_i),
    .q_i       (q),
    .pin_in_i  (pin_in_i),
    .nbr_pin_i (nbr_pin_i),
    .fb_o      (fb_o)
  );

endmodule

// File: rtl/plm_macrocell_chk.sv
module plm_macrocell_chk #(
  parameter int NUM_PT     = 8,
  parameter int NUM_CELLS  = 8,
  parameter int CELL_IDX   = 3,
  parameter bit HAS_DED_FB = 1'b1
) (
  input logic              clk,
  input logic [NUM_PT-1:0] pterm_i,
  input logic              oe_n_i,
  input logic              glb_noreg_i,
  input logic              glb_regfam_i,
  input logic              loc_mode_i,
  input logic              loc_inv_i,
  input logic              pin_in_i,
  input logic              nbr_pin_i,
  input logic              pin_data_o,
  input logic              pin_oe_o,
  input logic              fb_o
);

  localparam bit IS_EDGE = (CELL_IDX == 0) || (CELL_IDX == NUM_CELLS - 1);

  bit primed;
  always_ff @(posedge clk) primed <= 1'b1;

  logic reg_mode, cio_mode, din_mode, dout_mode;
  assign reg_mode  = !glb_noreg_i && glb_regfam_i && !loc_mode_i;
  assign cio_mode  = glb_regfam_i && loc_mode_i;
  assign din_mode  = !glb_regfam_i && loc_mode_i;
  assign dout_mode = glb_noreg_i && !glb_regfam_i && !loc_mode_i;

  p_reg_capture_r1: assert property (@(posedge clk) disable iff (!primed)
    ($past(reg_mode) && reg_mode) |-> pin_data_o == ((|$past(pterm_i)) ^ $past(loc_inv_i)));

  p_reg_oe_r2: assert property (@(posedge clk) disable iff (!primed)
    reg_mode |-> pin_oe_o == !oe_n_i);

  p_reg_fb_r3: assert property (@(posedge clk) disable iff (!primed)
    reg_mode |-> fb_o == pin_data_o);

  p_dout_oe_r5: assert property (@(posedge clk) disable iff (!primed)
    dout_mode |-> pin_oe_o);

  p_cio_oe_r6: assert property (@(posedge clk) disable iff (!primed)
    cio_mode |-> pin_oe_o == pterm_i[0]);

  p_din_r8: assert property (@(posedge clk) disable iff (!primed)
    din_mode |-> (!pin_oe_o && fb_o == nbr_pin_i));

  if (!HAS_DED_FB) begin : g_nofb
    p_dout_nofb_r9: assert property (@(posedge clk) disable iff (!primed)
      dout_mode |-> !fb_o);
  end

  if (IS_EDGE) begin : g_edge
    p_edge_fb_r10: assert property (@(posedge clk) disable iff (!primed)
      (glb_noreg_i && glb_regfam_i && loc_mode_i) |-> fb_o == nbr_pin_i);
  end else begin : g_mid
    p_cio_fb_r7: assert property (@(posedge clk) disable iff (!primed)
      cio_mode |-> fb_o == pin_in_i);
  end

endmodule

bind plm_macrocell plm_macrocell_chk #(
  .NUM_PT(NUM_PT), .NUM_CELLS(NUM_CELLS), .CELL_IDX(CELL_IDX), .HAS_DED_FB(HAS_DED_FB)
) chk_i (
  .clk(clk), .pterm_i(pterm_i), .oe_n_i(oe_n_i), .glb_noreg_i(glb_noreg_i),
  .glb_regfam_i(glb_regfam_i), .loc_mode_i(loc_mode_i), .loc_inv_i(loc_inv_i),
  .pin_in_i(pin_in_i), .nbr_pin_i(nbr_pin_i), .pin_data_o(pin_data_o),
  .pin_oe_o(pin_oe_o), .fb_o(fb_o)
);

// File: tb/plm_macrocell_tb_top.sv
`timescale 1ns/1ps
module plm_macrocell_tb_top;

  localparam int NPT = 8;

  logic           clk = 1'b0;
  logic [NPT-1:0] pterm = '0;
  logic           oe_n = 1'b1;
  logic           g0 = 1'b0;
  logic           g1 = 1'b1;
  logic           lm = 1'b0;
  logic           inv = 1'b0;
  logic           pin_in = 1'b0;
  logic           nbr = 1'b0;

  logic d_mid, oe_mid, fb_mid;
  logic d_edge, oe_edge, fb_edge;
  logic d_nofb, oe_nofb, fb_nofb;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  plm_macrocell #(.CELL_IDX(3)) dut_i (
    .clk(clk), .pterm_i(pterm), .oe_n_i(oe_n), .glb_noreg_i(g0), .glb_regfam_i(g1),
    .loc_mode_i(lm), .loc_inv_i(inv), .pin_in_i(pin_in), .nbr_pin_i(nbr),
    .pin_data_o(d_mid), .pin_oe_o(oe_mid), .fb_o(fb_mid));

  plm_macrocell #(.CELL_IDX(0)) dut_edge_i (
    .clk(clk), .pterm_i(pterm), .oe_n_i(oe_n), .glb_noreg_i(g0), .glb_regfam_i(g1),
    .loc_mode_i(lm), .loc_inv_i(inv), .pin_in_i(pin_in), .nbr_pin_i(nbr),
    .pin_data_o(d_edge), .pin_oe_o(oe_edge), .fb_o(fb_edge));

  plm_macrocell #(.CELL_IDX(4), .HAS_DED_FB(1'b0)) dut_nofb_i (
    .clk(clk), .pterm_i(pterm), .oe_n_i(oe_n), .glb_noreg_i(g0), .glb_regfam_i(g1),
    .loc_mode_i(lm), .loc_inv_i(inv), .pin_in_i(pin_in), .nbr_pin_i(nbr),
    .pin_data_o(d_nofb), .pin_oe_o(oe_nofb), .fb_o(fb_nofb));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic set_cfg(input logic a, input logic b, input logic m, input logic v);
    @(negedge clk);
    g0 = a; g1 = b; lm = m; inv = v;
    #1;
  endtask

  task automatic t_preload();
    set_cfg(1'b0, 1'b1, 1'b0, 1'b0);
    pterm = 8'h04;
    oe_n = 1'b0;
    @(posedge clk); #1;
    chk("R1 preload data", d_mid, 1'b1);
    chk("R3 preload fb", fb_mid, 1'b1);
    chk("R2 oe low enables", oe_mid, 1'b1);
  endtask

  task automatic t_registered();
    set_cfg(1'b0, 1'b1, 1'b0, 1'b0);
    pterm = 8'h00;
    #1;
    chk("R1 holds before edge", d_mid, 1'b1);
    @(posedge clk); #1;
    chk("R1 captures zero", d_mid, 1'b0);
    chk("R3 fb follows reg", fb_mid, 1'b0);
    chk("R3 nofb cell fb follows reg", fb_nofb, 1'b0);
    @(negedge clk);
    inv = 1'b1;
    #1;
    chk("R1 inv change waits for edge", d_mid, 1'b0);
    @(posedge clk); #1;
    chk("R4 inverted capture", d_mid, 1'b1);
    pterm = 8'h80;
    @(posedge clk); #1;
    chk("R4 inverted high sum", d_mid, 1'b0);
    chk("R10 edge cell fb reg", fb_edge, 1'b0);
    @(negedge clk);
    oe_n = 1'b1;
    #1;
    chk("R2 oe high disables", oe_mid, 1'b0);
    oe_n = 1'b0;
    #1;
    chk("R2 oe low enables", oe_mid, 1'b1);
  endtask

  task automatic t_ded_out();
    set_cfg(1'b1, 1'b0, 1'b0, 1'b0);
    pterm = 8'h00; oe_n = 1'b1; nbr = 1'b1; pin_in = 1'b0;
    #1;
    chk("R5 oe always on", oe_mid, 1'b1);
    chk("R5 zero sum", d_mid, 1'b0);
    pterm = 8'h01;
    #1;
    chk("R5 first term counts", d_mid, 1'b1);
    inv = 1'b1;
    #1;
    chk("R4 inverted comb", d_mid, 1'b0);
    chk("R9 fb from neighbour", fb_mid, 1'b1);
    chk("R9 no-feedback cell", fb_nofb, 1'b0);
    nbr = 1'b0;
    #1;
    chk("R9 fb neighbour low", fb_mid, 1'b0);
  endtask

  task automatic t_cmb_io();
    set_cfg(1'b1, 1'b1, 1'b1, 1'b0);
    pterm = 8'h01;
    #1;
    chk("R6 enable from first term", oe_mid, 1'b1);
    chk("R6 first term excluded", d_mid, 1'b0);
    pterm = 8'h80;
    #1;
    chk("R6 enable off", oe_mid, 1'b0);
    chk("R6 upper term drives", d_mid, 1'b1);
    pin_in = 1'b1; nbr = 1'b0;
    #1;
    chk("R7 fb from own pin", fb_mid, 1'b1);
    chk("R10 edge fb from neighbour", fb_edge, 1'b0);
    chk("R10 edge oe still term", oe_edge, 1'b0);
    pin_in = 1'b0; nbr = 1'b1;
    #1;
    chk("R7 fb own pin low", fb_mid, 1'b0);
    chk("R10 edge fb neighbour high", fb_edge, 1'b1);
  endtask

  task automatic t_ded_in();
    set_cfg(1'b1, 1'b0, 1'b1, 1'b0);
    pterm = 8'hFF; oe_n = 1'b0; nbr = 1'b1; pin_in = 1'b0;
    #1;
    chk("R8 oe forced off", oe_mid, 1'b0);
    chk("R8 fb neighbour high", fb_mid, 1'b1);
    nbr = 1'b0; pin_in = 1'b1;
    #1;
    chk("R8 fb neighbour low", fb_mid, 1'b0);
    chk("R8 nofb cell still feeds back", fb_nofb, 1'b0);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(posedge clk);
    t_preload();
    t_registered();
    t_ded_out();
    t_cmb_io();
    t_ded_in();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule